// File: doc/BRIEF.md
# Burst Column Address Generator

This block produces the low-order column addresses for a single SDRAM read or write burst. A controller presents a start column and a 4-bit mode field taken from the mode register. It then pulses `start`. From the next cycle on, the block emits one column address per cycle with `col_valid` high, for as many cycles as the programmed burst length. `done` rises together with the final beat.

The ordering is chosen at run time and takes one of two forms:
- **Sequential:** the low bits count upward from the start offset and wrap inside the burst window.
- **Interleaved:** each beat's low bits are the start offset XOR the beat index.

Only the bits inside the burst window ever change. All column bits above the window are copied from the start column on every beat.

The mode field and start column are sampled only when a start is accepted. A start is accepted only while the block is idle. A reserved length code runs a two-beat burst, and that burst is flagged on `bad_len`.

Top module: `burst_colgen`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls with no start, `col_valid`, `done` and `bad_len` are low.
- R2: After an accepted start, `col_valid` is high for exactly burst-length consecutive cycles, beginning the cycle after the start. `done` is high only during the last of those cycles.
- R3: `mode[2:0]` selects the burst length: 3'b001 gives 2, 3'b010 gives 4 and 3'b011 gives 8.
- R4: With `mode[3]`=0 (sequential), beat i carries low bits (offset + i) mod length. Example: length 4 from offset 1 gives 1,2,3,0.
- R5: With `mode[3]`=1 (interleaved), beat i carries low bits offset XOR i. Example: length 8 from offset 5 gives 5,4,7,6,1,0,3,2.
- R6: The offset is taken only from the start column bits inside the window: bit 0 for length 2, bits 1:0 for length 4 and bits 2:0 for length 8. Every column bit outside the window equals the start column on every beat.
- R7: A reserved length code (000, 1xx) runs a length-2 burst. `bad_len` is high on each of its beats. `bad_len` stays low on bursts with valid codes.
- R8: A start that arrives while a burst is running, including in the `done` cycle, is ignored. It neither alters the running burst nor launches another.
- R9: Changes on `start_col` and `mode` during a burst have no effect on it. Both are sampled only at the accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Burst launch pulse, accepted only when idle |
| start_col | input | COL_W | Start column address |
| mode | input | 4 | [2:0] length code, [3] ordering type (0 sequential, 1 interleaved) |
| col_out | output | COL_W | Column address of the current beat |
| col_valid | output | 1 | High on every beat of a burst |
| done | output | 1 | High on the last beat |
| bad_len | output | 1 | High on the beats of a burst launched with a reserved length code |

## Verification
The bench covers several edge conditions:
- **Wrap at the window edge in sequential mode.** A design that forgets the wrap carries into higher column bits.
- **Nonzero offsets in interleaved mode.** Getting these wrong gives a plain count.
- **Start columns with set bits above the window.** An incorrect window mask corrupts these bits, or lets them steer the order.

Each length is also run at its widest offset, so an off-by-one beat counter shows up as a burst that is one beat too long or too short.

Starts are also raised mid-burst and in the `done` cycle. A design that accepts them restarts or extends the burst. At the same time the mode and column inputs are scrambled, which exposes any late sampling.

Reserved codes confirm the two-beat fallback and the flag.

// File: rtl/colgen_pkg.sv
package colgen_pkg;

    // Widest burst window: length 8 -> 3 offset bits
    localparam int ORD_W = 3;
    localparam int MODE_W = 4;

    typedef enum logic {
        ORD_SEQ = 1'b0,
        ORD_XOR = 1'b1
    } order_e;

    typedef struct packed {
        order_e           kind;
        logic [ORD_W-1:0] mask;   // burst length minus one
        logic             bad;    // reserved length code seen
    } burst_cfg_t;

    function automatic burst_cfg_t decode_mode(input logic [MODE_W-1:0] m);
        burst_cfg_t c;
        c.kind = order_e'(m[3]);
        c.bad  = 1'b0;
        unique case (m[2:0])
            3'b001:  c.mask = 3'd1;
            3'b010:  c.mask = 3'd3;
            3'b011:  c.mask = 3'd7;
            default: begin
                c.mask = 3'd1;
                c.bad  = 1'b1;
            end
        endcase
        return c;
    endfunction

    function automatic logic [ORD_W-1:0] beat_offset(
        input order_e           kind,
        input logic [ORD_W-1:0] base,
        input logic [ORD_W-1:0] idx,
        input logic [ORD_W-1:0] mask
    );
        logic [ORD_W-1:0] r;
        if (kind == ORD_XOR) r = base ^ idx;
        else                 r = base + idx;
        return r & mask;
    endfunction

endpackage

// File: rtl/colgen_cfg_reg.sv
module colgen_cfg_reg
    import colgen_pkg::*;
#(
    parameter int COL_W = 10
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                load,
    input  logic [COL_W-1:0]    col_in,
    input  logic [MODE_W-1:0]   mode_in,
    output logic [COL_W-1:0]    col_q,
    output burst_cfg_t          cfg_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            col_q <= '0;
            cfg_q <= '{kind: ORD_SEQ, mask: 3'd1, bad: 1'b0};
        end else if (load) begin
            col_q <= col_in;
            cfg_q <= decode_mode(mode_in);
        end
    end

endmodule

// File: rtl/colgen_beat_ctr.sv
module colgen_beat_ctr
    import colgen_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              launch,
    input  logic [ORD_W-1:0]  mask,
    output logic              busy,
    output logic [ORD_W-1:0]  idx,
    output logic              last
);

    assign last = busy && (idx == mask);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            idx  <= '0;
        end else if (launch) begin
            busy <= 1'b1;
            idx  <= '0;
        end else if (busy) begin
            if (last) begin
                busy <= 1'b0;
                idx  <= '0;
            end else begin
                idx <= idx + 1'b1;
            end
        end
    end

endmodule

// File: rtl/colgen_addr_mux.sv
module colgen_addr_mux
    import colgen_pkg::*;
#(
    parameter int COL_W = 10
) (
    input  logic [COL_W-1:0]  base_col,
    input  burst_cfg_t        cfg,
    input  logic [ORD_W-1:0]  idx,
    output logic [COL_W-1:0]  col
);

    logic [ORD_W-1:0] low;

    assign low = beat_offset(cfg.kind, base_col[ORD_W-1:0], idx, cfg.mask);

    generate
        for (genvar b = 0; b < COL_W; b++) begin : g_bit
            if (b < ORD_W) begin : g_win
                assign col[b] = cfg.mask[b] ? low[b] : base_col[b];
            end else begin : g_pass
                assign col[b] = base_col[b];
            end
        end
    endgenerate

endmodule

// File: rtl/burst_colgen.sv
module burst_colgen
    import colgen_pkg::*;
#(
    parameter int COL_W = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [COL_W-1:0]  start_col,
    input  logic [3:0]        mode,
    output logic [COL_W-1:0]  col_out,
    output logic              col_valid,
    output logic              done,
    output logic              bad_len
);

    logic              busy;
    logic              launch;
    logic              last;
    logic [ORD_W-1:0]  idx;
    logic [COL_W-1:0]  base_col;
    burst_cfg_t        cfg;

    assign launch = start && !busy;

    colgen_cfg_reg #(.COL_W(COL_W)) u_cfg (
        .clk     (clk),
        .rst     (rst),
        .load    (launch),
        .col_in  (start_col),
        .mode_in (mode),
        .col_q   (base_col),
        .cfg_q   (cfg)
    );

    colgen_beat_ctr u_ctr (
        .clk    (clk),
        .rst    (rst),
        .launch (launch),
        .mask   (cfg.mask),
        .busy   (busy),
        .idx    (idx),
        .last   (last)
    );

    colgen_addr_mux #(.COL_W(COL_W)) u_mux (
        .base_col (base_col),
        .cfg      (cfg),
        .idx      (idx),
        .col      (col_out)
    );

    assign col_valid = busy;
    assign done      = last;
    assign bad_len   = busy && cfg.bad;

endmodule

// File: rtl/burst_colgen_chk.sv
module burst_colgen_chk #(
    parameter int COL_W = 10
) (
    input logic              clk,
    input logic              rst,
    input logic              start,
    input logic [COL_W-1:0]  col_out,
    input logic              col_valid,
    input logic              done,
    input logic              bad_len
);

    logic [3:0] seen;

    always_ff @(posedge clk) begin
        if (rst)             seen <= '0;
        else if (done)       seen <= '0;
        else if (col_valid)  seen <= seen + 1'b1;
    end

    // R2
    done_in_burst_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> col_valid);

    // R2
    burst_continues_chk: assert property (@(posedge clk) disable iff (rst)
        col_valid && !done |=> col_valid);

    // R2
    gap_after_done_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !col_valid);

    // R8
    no_spontaneous_chk: assert property (@(posedge clk) disable iff (rst)
        !col_valid && !start |=> !col_valid);

    // R3
    burst_len_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> (seen == 4'd1 || seen == 4'd3 || seen == 4'd7));

    // R6
    upper_hold_chk: assert property (@(posedge clk) disable iff (rst)
        col_valid && !done |=> col_out[COL_W-1:3] == $past(col_out[COL_W-1:3]));

    // R7
    flag_in_burst_chk: assert property (@(posedge clk) disable iff (rst)
        bad_len |-> col_valid);

    // R7
    flag_steady_chk: assert property (@(posedge clk) disable iff (rst)
        col_valid && !done |=> $stable(bad_len));

endmodule

bind burst_colgen burst_colgen_chk #(.COL_W(COL_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .col_out   (col_out),
    .col_valid (col_valid),
    .done      (done),
    .bad_len   (bad_len)
);

// File: tb/burst_colgen_test.sv
module burst_colgen_test;

    localparam int COL_W = 10;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             start = 1'b0;
    logic [COL_W-1:0] start_col = '0;
    logic [3:0]       mode = 4'b0001;
    logic [COL_W-1:0] col_out;
    logic             col_valid;
    logic             done;
    logic             bad_len;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;   // 125 MHz

    burst_colgen #(.COL_W(COL_W)) uut (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .start_col (start_col),
        .mode      (mode),
        .col_out   (col_out),
        .col_valid (col_valid),
        .done      (done),
        .bad_len   (bad_len)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // One burst; glitch_at >= 0 raises start and scrambles inputs on that beat
    task automatic burst(input int code, input int kind, input int scol,
                         input int glitch_at, input string req);
        int bl;
        bit bad;
        int off;
        bad = !(code == 1 || code == 2 || code == 3);
        bl  = (code == 2) ? 4 : (code == 3) ? 8 : 2;
        off = scol % bl;
        @(negedge clk);
        start_col = scol[COL_W-1:0];
        mode      = {kind[0], code[2:0]};
        start     = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int i = 0; i < bl; i++) begin
            int low;
            int exp;
            low = kind ? (off ^ i) : ((off + i) % bl);
            exp = scol - off + low;
            chk(col_valid == 1'b1, req, $sformatf("valid beat %0d", i), col_valid, 1);
            chk(int'(col_out) == exp, req, $sformatf("col beat %0d", i), col_out, exp);
            chk(done == (i == bl - 1), req, $sformatf("done beat %0d", i), done, i == bl - 1);
            chk(bad_len == bad, req, $sformatf("flag beat %0d", i), bad_len, bad);
            if (i == glitch_at) begin
                start     = 1'b1;
                mode      = ~mode;
                start_col = ~start_col;
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
        end
        start = 1'b0;
        chk(col_valid == 1'b0, req, "valid after burst", col_valid, 0);
        chk(done == 1'b0, req, "done after burst", done, 0);
    endtask

    task automatic test_reset();
        rst   = 1'b1;
        start = 1'b1;
        repeat (3) @(negedge clk);
        chk(col_valid == 1'b0, "R1", "valid in reset", col_valid, 0);
        chk(done == 1'b0, "R1", "done in reset", done, 0);
        chk(bad_len == 1'b0, "R1", "flag in reset", bad_len, 0);
        start = 1'b0;
        rst   = 1'b0;
        @(negedge clk);
        chk(col_valid == 1'b0, "R1", "valid after reset", col_valid, 0);
    endtask

    task automatic test_sequential();
        burst(2, 0, 1, -1, "R4");          // 1,2,3,0
        burst(3, 0, 5, -1, "R4");          // 5,6,7,0,1,2,3,4
        burst(3, 0, 7, -1, "R2");          // widest offset, length 8
        burst(1, 0, 1, -1, "R3");          // length 2 wrap
    endtask

    task automatic test_interleave();
        burst(3, 1, 5, -1, "R5");          // 5,4,7,6,1,0,3,2
        burst(2, 1, 3, -1, "R5");          // 3,2,1,0
        burst(1, 1, 1, -1, "R9");          // type bit selects XOR
    endtask

    task automatic test_window();
        burst(1, 0, 10'h3AE, -1, "R6");    // bits above bit 0 fixed
        burst(2, 1, 10'h2B6, -1, "R6");    // bit 2 outside window kept
        burst(3, 0, 10'h155, -1, "R6");
    endtask

    task automatic test_reserved();
        burst(0, 0, 10'h013, -1, "R7");
        burst(7, 1, 10'h006, -1, "R7");
        burst(4, 0, 10'h001, -1, "R7");
    endtask

    task automatic test_ignored_start();
        burst(3, 0, 2, 3, "R8");           // mid-burst start and scramble
        burst(2, 1, 1, 3, "R8");           // start in the done cycle
        burst(2, 0, 10'h1F2, 0, "R9");     // inputs change on first beat
    endtask

    initial begin
        #(8 * 100000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        test_reset();
        test_sequential();
        test_interleave();
        test_window();
        test_reserved();
        test_ignored_start();
        repeat (3) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule